// File: doc/BRIEF.md
# Branch Prediction Control with History

This block makes the final next-PC choice for each control instruction in the fetch stage of a single-threaded core. It merges a direction-predictor verdict, a target-buffer lookup, the top of the return address stack and the decoded direct target into one taken flag and one predicted PC. It also drives the push and pop strobes of the return stack.

Each accepted prediction leaves a record in a 16-entry circular history queue. The record holds the sequence number, the PC, the predicted outcome and the return-stack bookkeeping. Three requests act on the queue.

- **Commit** retires records from the old end and trains the direction predictor with each one.
- **Squash** unwinds records from the young end and undoes what each did to the return stack.
- **Mispredict** runs a squash, then repairs the youngest surviving record. The repair trains the predictor and the target buffer with the resolved outcome.

The direction predictor, the target buffer and the return stack sit outside the block. The block drives their update strobes. A walk removes one record per clock cycle. While a walk runs, or while the queue is full, the stall output is high.

Top module: `brpred_ctl`

## Requirements
- R1: After reset, stall is low, both mispredict counters are zero and no update strobe is active.
- R2: The direction of an unconditional instruction is taken whatever dp_taken says. An accepted unconditional prediction pulses dp_uncond. A conditional instruction takes its direction from dp_taken.
- R3: A return is predicted not taken whenever ras_empty is high.
- R4: A taken return predicts ras_top_val as its target. Accepting it pulses ras_pop, and its record keeps ras_top_idx and ras_top_val.
- R5: An accepted call whose direction is taken pulses ras_push with its own PC and is recorded as a call. This holds even when the final prediction falls back to not taken.
- R6: Target selection for a taken instruction that is not a return:
  - A call that is both unconditional and direct (is_direct high) predicts dir_target.
  - Any other such instruction predicts btb_target when btb_hit is high.
  - Otherwise the prediction is not taken.
  - A not-taken prediction gives pred_pc = pc + 4.
- R7: A commit to N removes records from the old end, one per cycle, while their sequence number is at most N (16-bit unsigned compare). Each removal drives dp_upd_valid with the record's PC and predicted outcome. Stall is high from the cycle after the request until the walk ends, and a walk that removes k records keeps stall high for k+1 cycles.
- R8: A squash to N removes records from the young end, one per cycle, while their sequence number is greater than N. A removed return record pulses ras_restore with its saved index and value. A removed call record pulses ras_pop. Stall stays high for k+1 cycles.
- R9: A mispredict to N first squashes to N and then repairs the youngest remaining record. The repair drives dp_upd_valid with the actual outcome and btb_upd_valid with the corrected target, then removes the record. Stall is high for k+2 cycles.
- R10: A mispredict that meets an empty queue after its squash produces no predictor or target-buffer update.
- R11: With 16 records held, stall is high. A prediction presented then is neither recorded nor allowed to pulse ras_push or dp_uncond.
- R12: Every mispredict request increments mispred_cnt. ras_mispred_cnt also increments when the repaired record had used the return stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | A control instruction is presented for prediction |
| is_uncond | input | 1 | Instruction is unconditional |
| is_call | input | 1 | Instruction is a call |
| is_ret | input | 1 | Instruction is a return |
| is_direct | input | 1 | Target is encoded in the instruction |
| pc | input | AW | Instruction PC |
| seq_num | input | SW | Instruction sequence number |
| dir_target | input | AW | Decoded direct target |
| dp_taken | input | 1 | Direction predictor verdict |
| btb_hit | input | 1 | Target buffer holds a valid entry for pc |
| btb_target | input | AW | Target buffer entry |
| ras_empty | input | 1 | Return stack is empty |
| ras_top_idx | input | RIW | Return stack top index |
| ras_top_val | input | AW | Return stack top value |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SW | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SW | Youngest surviving sequence number |
| mispred_valid | input | 1 | Mispredict request |
| mispred_seq | input | SW | Sequence number of the mispredicted branch |
| mispred_taken | input | 1 | Resolved direction |
| mispred_target | input | AW | Resolved target |
| pred_taken | output | 1 | Predicted taken |
| pred_pc | output | AW | Predicted next PC |
| stall | output | 1 | Predictions are not accepted |
| dp_uncond | output | 1 | Unconditional-branch notice to the direction predictor |
| dp_upd_valid | output | 1 | Direction predictor training strobe |
| dp_upd_pc | output | AW | Training PC |
| dp_upd_taken | output | 1 | Training outcome |
| btb_upd_valid | output | 1 | Target buffer write strobe |
| btb_upd_pc | output | AW | Target buffer write PC |
| btb_upd_target | output | AW | Target buffer write value |
| ras_push | output | 1 | Return stack push |
| ras_push_val | output | AW | Value pushed |
| ras_pop | output | 1 | Return stack pop |
| ras_restore | output | 1 | Return stack restore |
| ras_restore_idx | output | RIW | Restored top index |
| ras_restore_val | output | AW | Restored top value |
| mispred_cnt | output | CW | Mispredict count |
| ras_mispred_cnt | output | CW | Mispredicts on return-stack records |

## Verification
The next-PC decision is swept over all 128 combinations of the class flags, the predictor verdict, the target-buffer hit and the return-stack emptiness. This separates the four target sources from one another and from the not-taken fallback.

Directed sequences mix calls, returns and conditional branches and then unwind them with a squash. Watching the restore and pop strobes, together with the bench's own return stack, shows whether each record undid its own stack action.

A mispredict is tried in three settings:
- after a call was unwound;
- on a surviving return record, which must bump the return-stack counter;
- on an empty queue, which must update nothing.

Finally the queue is filled to 16 records and drained by two commits. The oldest-first order of training PCs, together with the walk lengths, shows that each record is retired exactly once and that a prediction blocked by stall is never recorded.

// File: rtl/brpred_ctl.sv
module brpred_ctl #(
  parameter int AW         = 32,
  parameter int SW         = 16,
  parameter int DEPTH      = 16,
  parameter int RIW        = 4,
  parameter int CW         = 8,
  parameter int INST_BYTES = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pred_valid,
  input  logic           is_uncond,
  input  logic           is_call,
  input  logic           is_ret,
  input  logic           is_direct,
  input  logic [AW-1:0]  pc,
  input  logic [SW-1:0]  seq_num,
  input  logic [AW-1:0]  dir_target,
  input  logic           dp_taken,
  input  logic           btb_hit,
  input  logic [AW-1:0]  btb_target,
  input  logic           ras_empty,
  input  logic [RIW-1:0] ras_top_idx,
  input  logic [AW-1:0]  ras_top_val,
  input  logic           commit_valid,
  input  logic [SW-1:0]  commit_seq,
  input  logic           squash_valid,
  input  logic [SW-1:0]  squash_seq,
  input  logic           mispred_valid,
  input  logic [SW-1:0]  mispred_seq,
  input  logic           mispred_taken,
  input  logic [AW-1:0]  mispred_target,
  output logic           pred_taken,
  output logic [AW-1:0]  pred_pc,
  output logic           stall,
  output logic           dp_uncond,
  output logic           dp_upd_valid,
  output logic [AW-1:0]  dp_upd_pc,
  output logic           dp_upd_taken,
  output logic           btb_upd_valid,
  output logic [AW-1:0]  btb_upd_pc,
  output logic [AW-1:0]  btb_upd_target,
  output logic           ras_push,
  output logic [AW-1:0]  ras_push_val,
  output logic           ras_pop,
  output logic           ras_restore,
  output logic [RIW-1:0] ras_restore_idx,
  output logic [AW-1:0]  ras_restore_val,
  output logic [CW-1:0]  mispred_cnt,
  output logic [CW-1:0]  ras_mispred_cnt
);

  // DEPTH is expected to be a power of two so the pointers wrap naturally.
  localparam int PW = $clog2(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_COMMIT, S_SQUASH, S_REPAIR} state_t;

  state_t st;

  logic [SW-1:0]  q_seq  [DEPTH];
  logic [AW-1:0]  q_pc   [DEPTH];
  logic           q_tk   [DEPTH];
  logic           q_ras  [DEPTH];
  logic           q_call [DEPTH];
  logic [RIW-1:0] q_ridx [DEPTH];
  logic [AW-1:0]  q_rval [DEPTH];

  logic [PW-1:0] head, tail;
  logic [PW:0]   cnt;

  logic [SW-1:0] walk_seq;
  logic          walk_fix;
  logic          walk_act;
  logic [AW-1:0] walk_tgt;

  logic [PW-1:0] young;
  logic          busy, full, any_req, fire;
  logic          dir_tk, take_ret, take_other, direct_call;
  logic [AW-1:0] tgt;
  logic          cmt_go, sq_go, rp_go;

  assign young   = tail - 1'b1;
  assign busy    = st != S_IDLE;
  assign full    = cnt == (PW+1)'(DEPTH);
  assign stall   = busy | full;
  assign any_req = mispred_valid | squash_valid | commit_valid;
  assign fire    = pred_valid & ~stall & ~any_req;

  assign dir_tk      = (is_uncond | dp_taken) & ~(is_ret & ras_empty);
  assign take_ret    = dir_tk & is_ret;
  assign take_other  = dir_tk & ~is_ret;
  assign direct_call = is_call & is_uncond & is_direct;
  assign pred_taken  = take_ret | (take_other & (direct_call | btb_hit));
  assign tgt         = is_ret ? ras_top_val : (direct_call ? dir_target : btb_target);
  assign pred_pc     = pred_taken ? tgt : pc + AW'(INST_BYTES);

  assign dp_uncond    = fire & is_uncond;
  assign ras_push     = fire & take_other & is_call;
  assign ras_push_val = pc;

  assign cmt_go = (st == S_COMMIT) && (cnt != '0) && (q_seq[head] <= walk_seq);
  assign sq_go  = (st == S_SQUASH) && (cnt != '0) && (q_seq[young] > walk_seq);
  assign rp_go  = (st == S_REPAIR) && (cnt != '0);

  assign dp_upd_valid   = cmt_go | rp_go;
  assign dp_upd_pc      = cmt_go ? q_pc[head] : q_pc[young];
  assign dp_upd_taken   = cmt_go ? q_tk[head] : walk_act;
  assign btb_upd_valid  = rp_go;
  assign btb_upd_pc     = q_pc[young];
  assign btb_upd_target = walk_tgt;

  assign ras_restore     = sq_go & q_ras[young];
  assign ras_restore_idx = q_ridx[young];
  assign ras_restore_val = q_rval[young];
  assign ras_pop         = (fire & take_ret) | (sq_go & ~q_ras[young] & q_call[young]);

  always_ff @(posedge clk) begin
    if (fire) begin
      q_seq[tail]  <= seq_num;
      q_pc[tail]   <= pc;
      q_tk[tail]   <= pred_taken;
      q_ras[tail]  <= take_ret;
      q_call[tail] <= take_other & is_call;
      q_ridx[tail] <= ras_top_idx;
      q_rval[tail] <= ras_top_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st              <= S_IDLE;
      head            <= '0;
      tail            <= '0;
      cnt             <= '0;
      walk_seq        <= '0;
      walk_fix        <= 1'b0;
      walk_act        <= 1'b0;
      walk_tgt        <= '0;
      mispred_cnt     <= '0;
      ras_mispred_cnt <= '0;
    end else begin
      if (fire) begin
        tail <= tail + 1'b1;
        cnt  <= cnt + 1'b1;
      end
      if (cmt_go) begin
        head <= head + 1'b1;
        cnt  <= cnt - 1'b1;
      end
      if (sq_go || rp_go) begin
        tail <= young;
        cnt  <= cnt - 1'b1;
      end
      case (st)
        S_IDLE: begin
          if (mispred_valid) begin
            st          <= S_SQUASH;
            walk_seq    <= mispred_seq;
            walk_fix    <= 1'b1;
            walk_act    <= mispred_taken;
            walk_tgt    <= mispred_target;
            mispred_cnt <= mispred_cnt + 1'b1;
          end else if (squash_valid) begin
            st       <= S_SQUASH;
            walk_seq <= squash_seq;
            walk_fix <= 1'b0;
          end else if (commit_valid) begin
            st       <= S_COMMIT;
            walk_seq <= commit_seq;
          end
        end
        S_COMMIT: if (!cmt_go) st <= S_IDLE;
        S_SQUASH: if (!sq_go) st <= walk_fix ? S_REPAIR : S_IDLE;
        default: begin
          st <= S_IDLE;
          if (rp_go && q_ras[young]) ras_mispred_cnt <= ras_mispred_cnt + 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/brpred_ctl_chk.sv
module brpred_ctl_chk #(
  parameter int AW = 32,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pred_valid,
  input logic          is_uncond,
  input logic          is_call,
  input logic          is_ret,
  input logic          is_direct,
  input logic [AW-1:0] dir_target,
  input logic          ras_empty,
  input logic [AW-1:0] ras_top_val,
  input logic          pred_taken,
  input logic [AW-1:0] pred_pc,
  input logic          stall,
  input logic          dp_uncond,
  input logic          dp_upd_valid,
  input logic          btb_upd_valid,
  input logic          ras_push,
  input logic          ras_pop,
  input logic          ras_restore,
  input logic [CW-1:0] mispred_cnt
);

  a_r3_empty_return: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ret && ras_empty) |-> !pred_taken);

  a_r4_return_target: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ret && pred_taken) |-> (pred_pc == ras_top_val));

  a_r6_direct_call: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && is_uncond && is_call && is_direct && !is_ret) |-> (pred_taken && pred_pc == dir_target));

  a_r8_single_ras_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ras_push, ras_pop, ras_restore}));

  a_r9_btb_with_training: assert property (@(posedge clk) disable iff (!rst_n)
    btb_upd_valid |-> dp_upd_valid);

  a_r11_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!dp_uncond && !ras_push));

  a_r12_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (CW'(mispred_cnt - $past(mispred_cnt)) <= CW'(1)));

endmodule

bind brpred_ctl brpred_ctl_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .is_uncond(is_uncond),
  .is_call(is_call), .is_ret(is_ret), .is_direct(is_direct), .dir_target(dir_target),
  .ras_empty(ras_empty), .ras_top_val(ras_top_val), .pred_taken(pred_taken),
  .pred_pc(pred_pc), .stall(stall), .dp_uncond(dp_uncond), .dp_upd_valid(dp_upd_valid),
  .btb_upd_valid(btb_upd_valid), .ras_push(ras_push), .ras_pop(ras_pop),
  .ras_restore(ras_restore), .mispred_cnt(mispred_cnt)
);

// File: tb/test_brpred_ctl.sv
`timescale 1ns/1ps
module test_brpred_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic pred_valid = 0, is_uncond = 0, is_call = 0, is_ret = 0, is_direct = 0;
  logic [31:0] pc = 0, dir_target = 0, btb_target = 0, mispred_target = 0;
  logic [15:0] seq_num = 0, commit_seq = 0, squash_seq = 0, mispred_seq = 0;
  logic dp_taken = 0, btb_hit = 0, commit_valid = 0, squash_valid = 0;
  logic mispred_valid = 0, mispred_taken = 0;
  logic ras_empty, pred_taken, stall, dp_uncond, dp_upd_valid, dp_upd_taken;
  logic btb_upd_valid, ras_push, ras_pop, ras_restore;
  logic [3:0] ras_top_idx, ras_restore_idx;
  logic [31:0] ras_top_val, pred_pc, dp_upd_pc, btb_upd_pc, btb_upd_target;
  logic [31:0] ras_push_val, ras_restore_val;
  logic [7:0] mispred_cnt, ras_mispred_cnt;

  // bench return stack, with an override used by the decision sweep
  logic [31:0] rs [16];
  int rs_n = 0;
  logic ovr = 0, ovr_empty = 0;
  assign ras_empty   = ovr ? ovr_empty : (rs_n == 0);
  assign ras_top_idx = 4'(rs_n - 1);
  assign ras_top_val = ovr ? 32'h0000_ABC0 : rs[4'(rs_n - 1)];
  always @(posedge clk) begin
    if (ras_push) begin rs[4'(rs_n)] <= ras_push_val; rs_n <= rs_n + 1; end
    else if (ras_pop) rs_n <= rs_n - 1;
    else if (ras_restore) begin rs[ras_restore_idx] <= ras_restore_val; rs_n <= int'(ras_restore_idx) + 1; end
  end

  brpred_ctl i_brpred_ctl (.*);

  int checks = 0, fails = 0;
  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  logic s_tk, s_push, s_pop, s_unc; logic [31:0] s_pc, s_pushv;
  task automatic predict(input logic u, c, r, d, dpt, bh, input [31:0] p, dt, bt, input [15:0] s);
    is_uncond = u; is_call = c; is_ret = r; is_direct = d; dp_taken = dpt; btb_hit = bh;
    pc = p; dir_target = dt; btb_target = bt; seq_num = s; pred_valid = 1;
    #5;
    s_tk = pred_taken; s_pc = pred_pc; s_push = ras_push; s_pushv = ras_push_val;
    s_pop = ras_pop; s_unc = dp_uncond;
    @(negedge clk); pred_valid = 0;
  endtask

  int n_dp, n_btb, n_rst, n_pop, busy;
  logic [31:0] l_dp_pc [32]; logic l_dp_tk [32];
  logic [31:0] l_btb_pc [32], l_btb_tg [32], l_rst_val [32]; logic [3:0] l_rst_idx [32];
  task automatic run_walk();
    n_dp = 0; n_btb = 0; n_rst = 0; n_pop = 0; busy = 0;
    @(negedge clk); commit_valid = 0; squash_valid = 0; mispred_valid = 0;
    while (stall && busy < 40) begin
      if (dp_upd_valid) begin l_dp_pc[n_dp] = dp_upd_pc; l_dp_tk[n_dp] = dp_upd_taken; n_dp++; end
      if (btb_upd_valid) begin l_btb_pc[n_btb] = btb_upd_pc; l_btb_tg[n_btb] = btb_upd_target; n_btb++; end
      if (ras_restore) begin l_rst_idx[n_rst] = ras_restore_idx; l_rst_val[n_rst] = ras_restore_val; n_rst++; end
      if (ras_pop) n_pop++;
      busy++; @(negedge clk);
    end
  endtask
  task automatic do_commit(input [15:0] s);  commit_valid = 1; commit_seq = s; run_walk(); endtask
  task automatic do_squash(input [15:0] s);  squash_valid = 1; squash_seq = s; run_walk(); endtask
  task automatic do_mis(input [15:0] s, input logic t, input [31:0] g);
    mispred_valid = 1; mispred_seq = s; mispred_taken = t; mispred_target = g; run_walk();
  endtask

  logic done = 0;
  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++; $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    // R1 reset state
    chk(stall == 0, "R1 stall", stall, 0);
    chk(mispred_cnt == 0, "R1 mispred_cnt", mispred_cnt, 0);
    chk(ras_mispred_cnt == 0, "R1 ras_mispred_cnt", ras_mispred_cnt, 0);
    chk(!dp_upd_valid && !btb_upd_valid, "R1 strobes", {dp_upd_valid, btb_upd_valid}, 0);

    // R2 R3 R4 R6: decision sweep with pred_valid low
    ovr = 1;
    for (int k = 0; k < 128; k++) begin
      logic u, c, r, d, dpt, bh, e, et; logic [31:0] ep;
      {u, c, r, d, dpt, bh, e} = 7'(k);
      is_uncond = u; is_call = c; is_ret = r; is_direct = d; dp_taken = dpt;
      btb_hit = bh; ovr_empty = e; pc = 32'h2000; dir_target = 32'h3000; btb_target = 32'h4000;
      #2;
      et = (u | dpt) & ~(r & e);
      if (et && !r && !(c && u && d) && !bh) et = 0;
      ep = !et ? 32'h2004 : r ? 32'h0000_ABC0 : (c && u && d) ? 32'h3000 : 32'h4000;
      chk(pred_taken == et, "R2/R3 taken sweep", pred_taken, et);
      chk(pred_pc == ep, "R4/R6 pc sweep", pred_pc, ep);
      @(negedge clk);
    end
    ovr = 0;

    // R5 R6: direct call
    predict(1, 1, 0, 1, 0, 0, 32'h100, 32'h400, 0, 1);
    chk(s_tk && s_pc == 32'h400, "R6 direct call target", s_pc, 32'h400);
    chk(s_push && s_pushv == 32'h100, "R5 call push", s_pushv, 32'h100);
    chk(s_unc, "R2 uncond notice", s_unc, 1);
    // R4 return
    predict(1, 0, 1, 0, 0, 0, 32'h404, 0, 0, 2);
    chk(s_tk && s_pc == 32'h100, "R4 return target", s_pc, 32'h100);
    chk(s_pop, "R4 return pop", s_pop, 1);
    predict(0, 0, 0, 0, 1, 1, 32'h108, 0, 32'h200, 3);
    chk(s_tk && s_pc == 32'h200 && !s_unc, "R6 btb target", s_pc, 32'h200);
    predict(0, 0, 0, 0, 0, 1, 32'h20C, 0, 32'h200, 4);
    chk(!s_tk && s_pc == 32'h210, "R2 cond not taken", s_pc, 32'h210);
    // R8 squash to 1
    do_squash(1);
    chk(busy == 4, "R8 squash cycles", busy, 4);
    chk(n_rst == 1 && l_rst_idx[0] == 0 && l_rst_val[0] == 32'h100, "R8 restore", l_rst_val[0], 32'h100);
    chk(n_dp == 0 && n_pop == 0, "R8 no other strobes", n_dp + n_pop, 0);
    chk(!ras_empty && ras_top_val == 32'h100, "R8 stack after squash", ras_top_val, 32'h100);
    // R7 commit
    do_commit(1);
    chk(busy == 2 && n_dp == 1, "R7 commit cycles", busy, 2);
    chk(l_dp_pc[0] == 32'h100 && l_dp_tk[0], "R7 commit training", l_dp_pc[0], 32'h100);

    // R5 R9 R12: indirect call without target buffer hit, then mispredict
    predict(0, 0, 0, 0, 0, 0, 32'h300, 0, 0, 10);
    predict(1, 1, 0, 0, 0, 0, 32'h310, 0, 0, 11);
    chk(!s_tk && s_pc == 32'h314, "R6 btb miss fallback", s_pc, 32'h314);
    chk(s_push && s_pushv == 32'h310, "R5 push on fallback", s_pushv, 32'h310);
    predict(0, 0, 0, 0, 1, 1, 32'h320, 0, 32'h600, 12);
    do_mis(10, 1, 32'h380);
    chk(busy == 4, "R9 mispredict cycles", busy, 4);
    chk(n_pop == 1 && n_rst == 0, "R8 call pop on squash", n_pop, 1);
    chk(n_dp == 1 && l_dp_pc[0] == 32'h300 && l_dp_tk[0] == 1, "R9 repair training", l_dp_pc[0], 32'h300);
    chk(n_btb == 1 && l_btb_pc[0] == 32'h300 && l_btb_tg[0] == 32'h380, "R9 btb repair", l_btb_tg[0], 32'h380);
    chk(ras_top_val == 32'h100 && rs_n == 1, "R8 stack after call pop", rs_n, 1);
    chk(mispred_cnt == 1 && ras_mispred_cnt == 0, "R12 counters", mispred_cnt, 1);

    // R12 repaired return record
    predict(1, 0, 1, 0, 0, 0, 32'h700, 0, 0, 20);
    chk(s_tk && s_pc == 32'h100, "R4 return target", s_pc, 32'h100);
    do_mis(20, 0, 32'h704);
    chk(busy == 2 && n_dp == 1 && l_dp_tk[0] == 0, "R9 repair outcome", l_dp_tk[0], 0);
    chk(n_btb == 1 && l_btb_tg[0] == 32'h704, "R9 btb value", l_btb_tg[0], 32'h704);
    chk(mispred_cnt == 2 && ras_mispred_cnt == 1, "R12 ras counter", ras_mispred_cnt, 1);

    // R10 empty queue
    do_mis(5, 1, 32'h999);
    chk(n_dp == 0 && n_btb == 0, "R10 no update", n_dp + n_btb, 0);
    chk(mispred_cnt == 3 && ras_mispred_cnt == 1, "R12 count on empty", mispred_cnt, 3);

    // R11 fill
    for (int i = 0; i < 16; i++) predict(0, 0, 0, 0, 0, 0, 32'h1000 + 4 * i, 0, 0, 16'(30 + i));
    chk(stall == 1, "R11 stall when full", stall, 1);
    predict(1, 1, 0, 1, 0, 0, 32'h5000, 32'h6000, 0, 46);
    chk(!s_push && !s_unc, "R11 blocked prediction", {s_push, s_unc}, 0);
    do_commit(37);
    chk(busy == 9 && n_dp == 8, "R7 partial commit", n_dp, 8);
    for (int i = 0; i < 8; i++)
      chk(l_dp_pc[i] == 32'h1000 + 4 * i && !l_dp_tk[i], "R7 commit order", l_dp_pc[i], 32'h1000 + 4 * i);
    do_commit(16'hFFFF);
    chk(busy == 9 && n_dp == 8, "R11 nothing extra recorded", n_dp, 8);
    for (int i = 0; i < 8; i++)
      chk(l_dp_pc[i] == 32'h1020 + 4 * i, "R7 commit order rest", l_dp_pc[i], 32'h1020 + 4 * i);
    chk(stall == 0, "R7 stall released", stall, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule